// File: doc/BRIEF.md
# Ownership-Pending Store Queue with Load Forwarding

This block sits between a core's store port and its write-back data cache. A store to a line that the core does not yet own is accepted into a small in-order queue at once. In the same cycle an invalidation request goes out to the other cores, tagged with the queue slot that holds the store. Each peer answers with an acknowledgement carrying that slot tag. A queued store is written into the cache only once every peer has acknowledged its slot and every older store has already been written. Until then its data is private to this core.

Loads probe the queue before the cache. When one or more queued stores match the load address, the youngest of them supplies the data and byte enables. A barrier request closes the store port and holds it closed until the queue has fully drained. A one-cycle completion pulse then marks the point at which all earlier stores are in the cache.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, while `inv_valid`, `cw_valid`, `ld_hit` and `bar_done` are 0.
- R2: A store is accepted in a cycle where `st_valid` and `st_ready` are both 1. In that same cycle `inv_valid` is 1, `inv_addr` equals `st_addr`, and `inv_tag` is the slot index. Slots are handed out in rotating order 0,1,...,DEPTH-1,0,... starting from 0 after reset.
- R3: A queued store appears on the cache write port only after NPEER acknowledgements (`ack_valid` with `ack_tag` equal to its slot) have been received. When it is at the head, `cw_valid` rises in the cycle after the last acknowledgement.
- R4: Stores are written to the cache strictly in acceptance order. A younger store whose acknowledgements are complete waits behind an older one whose acknowledgements are not.
- R5: When any queued store has an address equal to `ld_addr`, `ld_hit` is 1 in the same cycle. `ld_data` and `ld_be` then come from the youngest such store.
- R6: A load whose address matches no queued store gives `ld_hit`=0. Once a store has been written to the cache, it no longer matches.
- R7: With DEPTH stores queued, `st_ready` is 0. A store presented while `st_ready` is 0 is dropped: it raises no `inv_valid`, is never forwarded and is never written.
- R8: From the cycle `bar_req` is 1 until the barrier completes, `st_ready` is 0.
- R9: `bar_done` is a single-cycle pulse. It comes in the cycle after the last queued store is written to the cache, or in the cycle after `bar_req` when the queue is already empty. `st_ready` returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| inv_valid | output | 1 | Invalidation request to peers |
| inv_addr | output | AW | Address being invalidated |
| inv_tag | output | log2(DEPTH) | Slot tag for the acknowledgements |
| ack_valid | input | 1 | One peer acknowledgement |
| ack_tag | input | log2(DEPTH) | Slot being acknowledged |
| cw_valid | output | 1 | Cache write of the head store |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| cw_be | output | DW/8 | Cache write byte enables |
| ld_addr | input | AW | Load probe address |
| ld_hit | output | 1 | A queued store matches the load |
| ld_data | output | DW | Forwarded data |
| ld_be | output | DW/8 | Forwarded byte enables |
| bar_req | input | 1 | Write-barrier request pulse |
| bar_done | output | 1 | Barrier complete pulse |

## Verification
A wrong acknowledgement count or head pointer shows on the cache port within one cycle of the deciding acknowledgement. The write either appears too early, or the order of written addresses departs from acceptance order. A stale valid bit shows up immediately as a forwarding hit on a load probe after the write. A misordered age search returns older data for a repeated address in the same cycle as the probe. A fault in the occupancy or barrier state shows as `st_ready` wrong while the queue is full or during a barrier, or as `bar_done` arriving in a cycle other than the one following the final write.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // slot reached by walking k places forward from the head, wrapping at depth
  function automatic int unsigned age_slot(input int unsigned head,
                                           input int unsigned k,
                                           input int unsigned depth);
    return (head + k) % depth;
  endfunction

  // an entry may leave once every peer has answered
  function automatic bit acks_done(input int unsigned cnt, input int unsigned need);
    return cnt >= need;
  endfunction
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          bar_req,
  input  logic          head_acked,
  output logic          st_ready,
  output logic          accept,
  output logic          retire,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [OW-1:0] occ,
  output logic          full,
  output logic          bar_busy,
  output logic          bar_done
);
  logic [OW-1:0] occ_next;

  assign full     = (occ == OW'(DEPTH));
  assign st_ready = !full && !bar_busy && !bar_req;
  assign accept   = st_valid && st_ready;
  assign retire   = head_acked && (occ != '0);
  assign occ_next = occ + OW'(accept) - OW'(retire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      occ      <= '0;
      bar_busy <= 1'b0;
      bar_done <= 1'b0;
    end else begin
      occ <= occ_next;
      if (accept) tail <= tail + 1'b1;
      if (retire) head <= head + 1'b1;
      bar_done <= 1'b0;
      if ((bar_busy || bar_req) && occ_next == '0) begin
        bar_busy <= 1'b0;
        bar_done <= 1'b1;
      end else if (bar_req) begin
        bar_busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NPEER = 3,
  localparam int IW = $clog2(DEPTH),
  localparam int BW = DW / 8,
  localparam int CW = $clog2(NPEER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [IW-1:0] tail,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic          retire,
  input  logic [IW-1:0] head,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_tag,
  output logic          head_acked,
  output logic [DEPTH-1:0] vld,
  output logic [AW-1:0] e_addr [DEPTH],
  output logic [DW-1:0] e_data [DEPTH],
  output logic [BW-1:0] e_be   [DEPTH]
);
  logic [CW-1:0] ack_cnt [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic alloc_here;
    assign alloc_here = accept && (tail == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]     <= 1'b0;
        ack_cnt[g] <= '0;
      end else if (alloc_here) begin
        vld[g]     <= 1'b1;
        ack_cnt[g] <= '0;
      end else begin
        if (retire && head == IW'(g)) vld[g] <= 1'b0;
        if (ack_valid && ack_tag == IW'(g) && ack_cnt[g] != CW'(NPEER))
          ack_cnt[g] <= ack_cnt[g] + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_here) begin
        e_addr[g] <= st_addr;
        e_data[g] <= st_data;
        e_be[g]   <= st_be;
      end
    end
  end

  assign head_acked = vld[head] &&
                      sb_pkg::acks_done(32'(ack_cnt[head]), NPEER);
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int BW = DW / 8
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] vld,
  input  logic [AW-1:0]    e_addr [DEPTH],
  input  logic [DW-1:0]    e_data [DEPTH],
  input  logic [BW-1:0]    e_be   [DEPTH],
  input  logic [AW-1:0]    ld_addr,
  output logic             ld_hit,
  output logic [DW-1:0]    ld_data,
  output logic [BW-1:0]    ld_be
);
  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    ld_be   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] s;
      s = IW'(sb_pkg::age_slot(32'(head), k, DEPTH));
      if (vld[s] && e_addr[s] == ld_addr) begin
        ld_hit  = 1'b1;
        ld_data = e_data[s];
        ld_be   = e_be[s];
      end
    end
  end
endmodule

// File: rtl/store_fwd_buf.sv
module store_fwd_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NPEER = 3,
  localparam int IW = $clog2(DEPTH),
  localparam int BW = DW / 8,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  output logic          inv_valid,
  output logic [AW-1:0] inv_addr,
  output logic [IW-1:0] inv_tag,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_tag,
  output logic          cw_valid,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data,
  output logic [BW-1:0] cw_be,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic [BW-1:0] ld_be,
  input  logic          bar_req,
  output logic          bar_done
);
  logic          accept, retire, head_acked, full, bar_busy;
  logic [IW-1:0] head, tail;
  logic [OW-1:0] occ;
  logic [DEPTH-1:0] vld;
  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [BW-1:0] e_be   [DEPTH];

  sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .bar_req(bar_req),
    .head_acked(head_acked), .st_ready(st_ready), .accept(accept),
    .retire(retire), .head(head), .tail(tail), .occ(occ), .full(full),
    .bar_busy(bar_busy), .bar_done(bar_done)
  );

  sb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NPEER(NPEER)) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .tail(tail),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .retire(retire), .head(head), .ack_valid(ack_valid), .ack_tag(ack_tag),
    .head_acked(head_acked), .vld(vld), .e_addr(e_addr), .e_data(e_data),
    .e_be(e_be)
  );

  sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .head(head), .vld(vld), .e_addr(e_addr), .e_data(e_data), .e_be(e_be),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be)
  );

  assign inv_valid = accept;
  assign inv_addr  = st_addr;
  assign inv_tag   = tail;

  assign cw_valid = retire;
  assign cw_addr  = e_addr[head];
  assign cw_data  = e_data[head];
  assign cw_be    = e_be[head];
endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
  parameter int DEPTH = 8,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_ready,
  input logic          inv_valid,
  input logic          cw_valid,
  input logic          ld_hit,
  input logic          bar_done,
  input logic          bar_busy,
  input logic          full,
  input logic [OW-1:0] occ
);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inv_valid);

  // R2
  alloc_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !cw_valid) |=> occ == $past(occ) + 1'b1);

  // R4
  no_write_from_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> occ != '0);

  // R5
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> occ != '0);

  // R8
  barrier_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_busy |-> !st_ready);

  // R9
  bar_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !bar_done);

  // R9
  bar_done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |-> (occ == '0 && !bar_busy));
endmodule

bind store_fwd_buf sb_chk #(.DEPTH(DEPTH)) u_sb_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .inv_valid(inv_valid),
  .cw_valid(cw_valid), .ld_hit(ld_hit), .bar_done(bar_done),
  .bar_busy(bar_busy), .full(full), .occ(occ)
);

// File: tb/test_store_fwd_buf.sv
`timescale 1ns/1ps
module test_store_fwd_buf;
  localparam int DEPTH = 8, AW = 32, DW = 32, NPEER = 3;
  localparam int IW = $clog2(DEPTH), BW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, ack_valid = 1'b0, bar_req = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic [IW-1:0] ack_tag = '0;
  logic st_ready, inv_valid, cw_valid, ld_hit, bar_done;
  logic [AW-1:0] inv_addr, cw_addr;
  logic [IW-1:0] inv_tag;
  logic [DW-1:0] cw_data, ld_data;
  logic [BW-1:0] cw_be, ld_be;

  always #4 clk = ~clk;

  store_fwd_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NPEER(NPEER)) i_store_fwd_buf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_tag(inv_tag),
    .ack_valid(ack_valid), .ack_tag(ack_tag), .cw_valid(cw_valid),
    .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be), .bar_req(bar_req),
    .bar_done(bar_done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model of the queue
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  logic [IW-1:0] q_tag[$];
  int            m_ack[DEPTH];
  logic [IW-1:0] next_tag = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // cache port monitor: R3 and R4, order and ack completion
  always @(negedge clk) begin
    if (rst_n && cw_valid) begin
      if (q_addr.size() == 0) chk(0, "R4 write with empty model", 64'(cw_addr), 0);
      else begin
        chk(cw_addr == q_addr[0], "R4 write order addr", 64'(cw_addr), 64'(q_addr[0]));
        chk(cw_data == q_data[0], "R4 write order data", 64'(cw_data), 64'(q_data[0]));
        chk(m_ack[q_tag[0]] == NPEER, "R3 write before all acks",
            64'(m_ack[q_tag[0]]), 64'(NPEER));
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [BW-1:0] be);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    #1;
    chk(inv_valid == 1, "R2 inv_valid on accept", 64'(inv_valid), 1);
    chk(inv_addr == a, "R2 inv_addr", 64'(inv_addr), 64'(a));
    chk(inv_tag == next_tag, "R2 slot tag order", 64'(inv_tag), 64'(next_tag));
    q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(next_tag);
    m_ack[next_tag] = 0;
    next_tag = next_tag + 1'b1;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic send_ack(input logic [IW-1:0] t);
    @(negedge clk);
    ack_valid = 1; ack_tag = t;
    m_ack[t]++;
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic ack_full(input logic [IW-1:0] t);
    for (int i = 0; i < NPEER; i++) send_ack(t);
  endtask

  task automatic drain_all();
    logic [IW-1:0] tags[$];
    tags = q_tag;
    foreach (tags[i]) ack_full(tags[i]);
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, "R4 all stores written", 64'(q_addr.size()), 0);
  endtask

  task automatic probe(input logic [AW-1:0] a, input bit hit,
                       input logic [DW-1:0] d, input logic [BW-1:0] be, input string req);
    @(negedge clk);
    ld_addr = a;
    #1;
    chk(ld_hit == hit, req, 64'(ld_hit), 64'(hit));
    if (hit) begin
      chk(ld_data == d, req, 64'(ld_data), 64'(d));
      chk(ld_be == be, req, 64'(ld_be), 64'(be));
    end
  endtask

  task automatic t_reset();
    #1;
    chk(st_ready == 1, "R1 st_ready", 64'(st_ready), 1);
    chk(inv_valid == 0, "R1 inv_valid", 64'(inv_valid), 0);
    chk(cw_valid == 0, "R1 cw_valid", 64'(cw_valid), 0);
    chk(ld_hit == 0, "R1 ld_hit", 64'(ld_hit), 0);
    chk(bar_done == 0, "R1 bar_done", 64'(bar_done), 0);
  endtask

  task automatic t_basic();
    do_store(32'h100, 32'hA5A5_0001, 4'hF);
    probe(32'h100, 1, 32'hA5A5_0001, 4'hF, "R5 single hit");
    for (int i = 0; i < NPEER - 1; i++) begin
      send_ack(0);
      #1 chk(cw_valid == 0, "R3 early write", 64'(cw_valid), 0);
    end
    send_ack(0);
    #1 chk(cw_valid == 1, "R3 write after last ack", 64'(cw_valid), 1);
    @(negedge clk);
    #1 chk(ld_hit == 0, "R6 retired no longer hits", 64'(ld_hit), 0);
  endtask

  task automatic t_order();
    do_store(32'h200, 32'h0000_0B0B, 4'hF);
    do_store(32'h300, 32'h0000_0C0C, 4'hF);
    ack_full(q_tag[1]);
    repeat (2) @(negedge clk);
    #1 chk(cw_valid == 0, "R4 younger waits", 64'(cw_valid), 0);
    chk(q_addr.size() == 2, "R4 nothing written", 64'(q_addr.size()), 2);
    ack_full(q_tag[0]);
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, "R4 both written in order", 64'(q_addr.size()), 0);
  endtask

  task automatic t_forward();
    do_store(32'h400, 32'h1111_1111, 4'hF);
    do_store(32'h500, 32'h3333_3333, 4'h1);
    do_store(32'h400, 32'h2222_2222, 4'h3);
    probe(32'h400, 1, 32'h2222_2222, 4'h3, "R5 youngest of two");
    probe(32'h500, 1, 32'h3333_3333, 4'h1, "R5 other address");
    probe(32'h600, 0, '0, '0, "R6 no match");
    drain_all();
    probe(32'h400, 0, '0, '0, "R6 miss after drain");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) do_store(32'h1000 + 32'(i), 32'hF000 + 32'(i), 4'hF);
    #1 chk(st_ready == 0, "R7 st_ready low when full", 64'(st_ready), 0);
    @(negedge clk);
    st_valid = 1; st_addr = 32'h2000; st_data = 32'hDEAD; st_be = 4'hF;
    #1 chk(inv_valid == 0, "R7 dropped store no inv", 64'(inv_valid), 0);
    @(negedge clk);
    st_valid = 0;
    probe(32'h2000, 0, '0, '0, "R7 dropped store not forwarded");
    probe(32'h1007, 1, 32'hF007, 4'hF, "R5 last slot hit");
    drain_all();
    #1 chk(st_ready == 1, "R7 ready after drain", 64'(st_ready), 1);
  endtask

  task automatic t_barrier();
    bit prev_cw, seen;
    do_store(32'h700, 32'h7777, 4'hF);
    do_store(32'h800, 32'h8888, 4'hF);
    @(negedge clk);
    bar_req = 1;
    #1 chk(st_ready == 0, "R8 ready low in bar_req cycle", 64'(st_ready), 0);
    @(negedge clk);
    bar_req = 0;
    st_valid = 1; st_addr = 32'h900; st_data = 32'h9999; st_be = 4'hF;
    #1;
    chk(st_ready == 0, "R8 ready low during barrier", 64'(st_ready), 0);
    chk(inv_valid == 0, "R8 store held off", 64'(inv_valid), 0);
    @(negedge clk);
    st_valid = 0;
    chk(bar_done == 0, "R9 no early done", 64'(bar_done), 0);
    ack_full(q_tag[0]);
    ack_full(q_tag[1]);
    prev_cw = cw_valid;
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (bar_done) begin
        seen = 1;
        chk(prev_cw == 1, "R9 done right after last write", 64'(prev_cw), 1);
        chk(st_ready == 1, "R9 ready with done", 64'(st_ready), 1);
        chk(q_addr.size() == 0, "R9 all written before done", 64'(q_addr.size()), 0);
      end else prev_cw = cw_valid;
    end
    chk(seen, "R9 done seen", 64'(seen), 1);
    @(negedge clk);
    chk(bar_done == 0, "R9 done is one cycle", 64'(bar_done), 0);
    probe(32'h900, 0, '0, '0, "R8 held store not queued");
    // barrier on an empty queue
    @(negedge clk);
    bar_req = 1;
    @(negedge clk);
    bar_req = 0;
    #1 chk(bar_done == 1, "R9 empty barrier done", 64'(bar_done), 1);
    @(negedge clk);
    chk(bar_done == 0, "R9 empty barrier pulse", 64'(bar_done), 0);
  endtask

  initial begin
    #400000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    foreach (m_ack[i]) m_ack[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_order();
    t_forward();
    t_full();
    t_barrier();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule